// File: doc/BRIEF.md
# SDRAM Refresh and Power-Down Sequencer

This block handles refresh and low-power entry for a small SDRAM controller. A four-bit control field picks the behaviour. With refresh switched off the block stays quiet. In timed auto-refresh mode an internal interval counter paces the refresh commands. In low-power mode the block enters self-refresh at once, or enters deep power-down when the deep bit is set. A separate bit moves command launch and read-data capture to the falling edge of the memory clock.

Every sequence starts the same way. The block raises a request to the access arbiter and waits for its grant. It then precharges all banks and waits the row-precharge time. Only after that does it issue the refresh, self-refresh or deep power-down command.

Leaving low power takes one step from software: clear the mode bit, or clear the deep bit while in deep power-down. The block then raises CKE and holds NOP for the exit time. Only after that does it hand the bus back to the arbiter. The busy flag shows when the memory is unavailable.

Top module: `sdram_refresh_seq`

## Requirements
- R1: After reset the block drives CKE high, drives NOP (CS#,RAS#,CAS#,WE# = 0,1,1,1) with A10 low, and holds busy, request and edge-select low.
- R2: While the refresh-enable input is 0, the block issues no command other than NOP and never raises its arbiter request.
- R3: With refresh-enable 1 and mode 0, auto-refresh commands (0,0,0,1 with CKE high) repeat every interval+1 clocks, where interval is the programmed count, as long as the arbiter grants promptly.
- R4: Before any refresh or low-power entry, the block raises its request and keeps NOP with busy low until the grant is seen. In the cycle after the grant is sampled it drives precharge-all (0,0,1,0 with A10 high) and raises busy.
- R5: Exactly T_RP NOP cycles separate the precharge-all from the following refresh, self-refresh or deep power-down command.
- R6: After an auto-refresh command, busy stays high for exactly T_RFC more NOP cycles and then drops.
- R7: With refresh-enable 1 and mode 1, the block raises its request within two clocks, whatever the interval count. After the precharge it issues self-refresh (0,0,0,1) with CKE low in the same cycle.
- R8: If the deep bit is 1 at entry time, the block issues deep power-down (0,1,1,0) with CKE low in place of self-refresh.
- R9: While in a low-power state with no exit condition, CKE stays low and busy stays high.
- R10: Clearing the mode bit ends self-refresh. Clearing the deep bit ends deep power-down. On exit, from the next cycle CKE is high and NOP is held with busy high for exactly T_XSR cycles. After that, busy and the request drop.
- R11: The edge-select output follows the low-frequency bit one clock later: 1 selects the falling edge for launch and capture, 0 selects the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_refresh_en | input | 1 | Refresh enable control bit |
| ctl_selfref | input | 1 | Mode bit: 0 timed auto-refresh, 1 immediate low-power entry |
| ctl_deep | input | 1 | Deep power-down chosen instead of self-refresh |
| ctl_lowfreq | input | 1 | Falling-edge launch and capture |
| refresh_interval | input | IVL_W | Auto-refresh interval count |
| arb_grant | input | 1 | Arbiter idle and granting the bus to this block |
| rf_req | output | 1 | Request for the bus to the arbiter |
| sd_busy | output | 1 | Memory unavailable for accesses |
| sd_cke | output | 1 | Clock enable pin |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_a10 | output | 1 | Address bit 10, high selects all banks on precharge |
| edge_sel | output | 1 | 1 = falling-edge timing, 0 = rising-edge timing |

## Verification
The pins are a direct decode of the sequencer state. A wrong state therefore shows up on CS#/RAS#/CAS#/WE#, CKE or busy in the very cycle it is entered. A bad wait counter or interval counter shows up as a wrong count of NOP cycles between commands, or as a wrong spacing between refreshes. The bench measures that spacing over several periods. A stale deep or mode decision shows up as the wrong entry code, or as CKE held low past the moment software released it.

// File: rtl/sdr_rf_pkg.sv
package sdr_rf_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_PRE,
        ST_TRP,
        ST_REF,
        ST_TRFC,
        ST_ENTER,
        ST_LP,
        ST_EXIT
    } seq_state_e;

    typedef enum logic {
        JOB_AUTO,
        JOB_LOWPWR
    } job_e;

    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } sd_pins_t;

endpackage

// File: rtl/sdr_rf_interval.sv
module sdr_rf_interval #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] interval,
    input  logic         take,
    output logic         pending
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pend;
    } ivl_regs_t;

    ivl_regs_t r_d, r_q;
    logic      hit;

    always_comb begin
        r_d = r_q;
        hit = run && (r_q.cnt == interval);
        if (!run) begin
            r_d.cnt  = '0;
            r_d.pend = 1'b0;
        end else begin
            r_d.cnt = hit ? '0 : r_q.cnt + W'(1);
            if (hit) begin
                r_d.pend = 1'b1;
            end else if (take) begin
                r_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pending = r_q.pend;

    // R3: a match under a steady interval restarts the count
    a_r3_count_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (run && r_q.cnt == interval) |=> (r_q.cnt == '0));

endmodule

// File: rtl/sdr_rf_delay.sv
module sdr_rf_delay #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

    // R5: without a reload the wait counter falls by one each clock
    a_r5_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

endmodule

// File: rtl/sdr_rf_cmd_enc.sv
module sdr_rf_cmd_enc
    import sdr_rf_pkg::*;
(
    input  seq_state_e state,
    input  logic       deep,
    output sd_pins_t   pins,
    output logic       req,
    output logic       busy
);

    always_comb begin
        pins = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
        unique case (state)
            ST_PRE: begin
                pins.ras_n = 1'b0;
                pins.we_n  = 1'b0;
                pins.a10   = 1'b1;
            end
            ST_REF: begin
                pins.ras_n = 1'b0;
                pins.cas_n = 1'b0;
            end
            ST_ENTER: begin
                pins.cke = 1'b0;
                if (deep) begin
                    pins.we_n = 1'b0;
                end else begin
                    pins.ras_n = 1'b0;
                    pins.cas_n = 1'b0;
                end
            end
            ST_LP: begin
                pins.cke = 1'b0;
            end
            default: begin
            end
        endcase
        req  = (state != ST_IDLE);
        busy = (state != ST_IDLE) && (state != ST_REQ);
    end

endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
    import sdr_rf_pkg::*;
#(
    parameter int IVL_W = 16,
    parameter int T_RP  = 3,
    parameter int T_RFC = 8,
    parameter int T_XSR = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_refresh_en,
    input  logic             ctl_selfref,
    input  logic             ctl_deep,
    input  logic             ctl_lowfreq,
    input  logic [IVL_W-1:0] refresh_interval,
    input  logic             arb_grant,
    output logic             rf_req,
    output logic             sd_busy,
    output logic             sd_cke,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic             sd_a10,
    output logic             edge_sel
);

    localparam int DLY_MAX = (T_RP > T_RFC) ? ((T_RP > T_XSR) ? T_RP : T_XSR)
                                            : ((T_RFC > T_XSR) ? T_RFC : T_XSR);
    localparam int DLY_W = $clog2(DLY_MAX + 1);
    localparam logic [DLY_W-1:0] LD_RP  = DLY_W'(T_RP - 1);
    localparam logic [DLY_W-1:0] LD_RFC = DLY_W'(T_RFC - 1);
    localparam logic [DLY_W-1:0] LD_XSR = DLY_W'(T_XSR - 1);

    typedef struct packed {
        seq_state_e state;
        job_e       job;
        logic       deep;
        logic       edge_fall;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic             auto_mode;
    logic             lp_want;
    logic             exit_lp;
    logic             pending;
    logic             take;
    logic             dly_load;
    logic [DLY_W-1:0] dly_val;
    logic             dly_zero;
    sd_pins_t         pins;

    assign auto_mode = ctl_refresh_en && !ctl_selfref;
    assign lp_want   = ctl_refresh_en && ctl_selfref;
    assign exit_lp   = !lp_want || (r_q.deep && !ctl_deep);

    sdr_rf_interval #(.W(IVL_W)) u_interval (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (auto_mode),
        .interval (refresh_interval),
        .take     (take),
        .pending  (pending)
    );

    sdr_rf_delay #(.W(DLY_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dly_val),
        .zero     (dly_zero)
    );

    always_comb begin
        r_d           = r_q;
        r_d.edge_fall = ctl_lowfreq;
        take          = 1'b0;
        dly_load      = 1'b0;
        dly_val       = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (lp_want) begin
                    r_d.state = ST_REQ;
                    r_d.job   = JOB_LOWPWR;
                end else if (pending && auto_mode) begin
                    r_d.state = ST_REQ;
                    r_d.job   = JOB_AUTO;
                    take      = 1'b1;
                end
            end
            ST_REQ: begin
                if (arb_grant) begin
                    r_d.state = ST_PRE;
                end
            end
            ST_PRE: begin
                dly_load  = 1'b1;
                dly_val   = LD_RP;
                r_d.state = ST_TRP;
            end
            ST_TRP: begin
                if (dly_zero) begin
                    if (r_q.job == JOB_AUTO) begin
                        r_d.state = ST_REF;
                    end else begin
                        r_d.state = ST_ENTER;
                        r_d.deep  = ctl_deep;
                    end
                end
            end
            ST_REF: begin
                dly_load  = 1'b1;
                dly_val   = LD_RFC;
                r_d.state = ST_TRFC;
            end
            ST_TRFC: begin
                if (dly_zero) begin
                    r_d.state = ST_IDLE;
                end
            end
            ST_ENTER: begin
                r_d.state = ST_LP;
            end
            ST_LP: begin
                if (exit_lp) begin
                    dly_load  = 1'b1;
                    dly_val   = LD_XSR;
                    r_d.state = ST_EXIT;
                end
            end
            ST_EXIT: begin
                if (dly_zero) begin
                    r_d.state = ST_IDLE;
                    r_d.deep  = 1'b0;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, job: JOB_AUTO, deep: 1'b0, edge_fall: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    sdr_rf_cmd_enc u_enc (
        .state (r_q.state),
        .deep  (r_q.deep),
        .pins  (pins),
        .req   (rf_req),
        .busy  (sd_busy)
    );

    assign sd_cke   = pins.cke;
    assign sd_cs_n  = pins.cs_n;
    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;
    assign sd_a10   = pins.a10;
    assign edge_sel = r_q.edge_fall;

    // R2: with refresh off an idle sequencer stays idle
    a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_refresh_en && r_q.state == ST_IDLE) |=> (r_q.state == ST_IDLE));

    // R4: a sampled grant brings precharge-all on the next clock
    a_r4_pre_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_REQ && arb_grant) |=>
        (!sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n && sd_a10 && sd_busy));

    // R6: busy only falls at the end of a timed wait
    a_r6_busy_falls_late: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_busy) |-> ($past(r_q.state) == ST_TRFC || $past(r_q.state) == ST_EXIT));

    // R9: clock enable remains low until an exit condition appears
    a_r9_cke_held_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cke && !exit_lp) |=> !sd_cke);

    // R10: an exit condition raises clock enable on the next clock with busy kept
    a_r10_cke_up_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_LP && exit_lp) |=> (sd_cke && sd_busy));

endmodule

// File: tb/sdram_refresh_seq_tb.sv
`timescale 1ns/1ps
module sdram_refresh_seq_tb;

    localparam int IVL_W = 16;
    localparam int T_RP  = 3;
    localparam int T_RFC = 8;
    localparam int T_XSR = 10;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_DPD = 4'b0110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, mode = 1'b0, deep = 1'b0, lowf = 1'b0, grant = 1'b0;
    logic [IVL_W-1:0] ivl = '0;
    logic rf_req, sd_busy, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10, edge_sel;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_refresh_seq #(.IVL_W(IVL_W), .T_RP(T_RP), .T_RFC(T_RFC), .T_XSR(T_XSR)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_refresh_en(en), .ctl_selfref(mode),
        .ctl_deep(deep), .ctl_lowfreq(lowf), .refresh_interval(ivl), .arb_grant(grant),
        .rf_req(rf_req), .sd_busy(sd_busy), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_a10(sd_a10),
        .edge_sel(edge_sel)
    );

    function automatic logic [3:0] cmd();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        en = 0; mode = 0; deep = 0; lowf = 0; grant = 0; ivl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_cmd(input logic [3:0] c, input int limit, output bit found);
        found = 0;
        for (int n = 0; n < limit; n++) begin
            @(negedge clk);
            if (cmd() == c) begin
                found = 1;
                break;
            end
        end
    endtask

    task automatic t_reset();
        do_reset();
        check(sd_cke == 1'b1, "R1 cke", int'(sd_cke), 1);
        check(cmd() == C_NOP && !sd_a10, "R1 cmd", int'(cmd()), int'(C_NOP));
        check(!sd_busy && !rf_req, "R1 busy/req", int'({sd_busy, rf_req}), 0);
        check(edge_sel == 1'b0, "R1 edge", int'(edge_sel), 0);
    endtask

    task automatic t_off();
        int viol = 0;
        do_reset();
        ivl = 16'd5; grant = 1'b1;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (cmd() != C_NOP || rf_req) viol++;
        end
        check(viol == 0, "R2 quiet", viol, 0);
    endtask

    task automatic t_period();
        bit f;
        int t0, t1, t2;
        do_reset();
        ivl = 16'd39; grant = 1'b1; en = 1'b1;
        wait_cmd(C_REF, 500, f); t0 = cyc;
        check(f, "R3 first refresh", int'(f), 1);
        wait_cmd(C_REF, 500, f); t1 = cyc;
        check(f && (t1 - t0) == 40, "R3 period", t1 - t0, 40);
        wait_cmd(C_REF, 500, f); t2 = cyc;
        check(f && (t2 - t1) == 40, "R3 period2", t2 - t1, 40);
        check(sd_cke == 1'b1, "R3 cke high", int'(sd_cke), 1);
        en = 1'b0;
    endtask

    task automatic t_grant();
        int viol = 0;
        int n;
        bit got = 0;
        do_reset();
        ivl = 16'd20; grant = 1'b0; en = 1'b1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (rf_req) begin got = 1; break; end
        end
        check(got, "R4 request", int'(got), 1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (cmd() != C_NOP || sd_busy || !rf_req) viol++;
        end
        check(viol == 0, "R4 wait for grant", viol, 0);
        grant = 1'b1;
        @(negedge clk);
        check(cmd() == C_PRE && sd_a10 && sd_busy, "R4 precharge", int'({cmd(), sd_a10}), int'({C_PRE, 1'b1}));
        n = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (cmd() == C_NOP) n++; else break;
        end
        check(n == T_RP, "R5 tRP", n, T_RP);
        check(cmd() == C_REF, "R5 refresh follows", int'(cmd()), int'(C_REF));
        n = 0;
        viol = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (sd_busy) begin
                n++;
                if (cmd() != C_NOP) viol++;
            end else break;
        end
        check(n == T_RFC && viol == 0, "R6 tRFC", n, T_RFC);
        en = 1'b0;
    endtask

    task automatic t_self();
        bit f;
        int n = 0;
        int viol = 0;
        do_reset();
        ivl = 16'hFFFF; grant = 1'b1; en = 1'b1; mode = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            n++;
            if (rf_req) break;
        end
        check(rf_req && n <= 2, "R7 immediate request", n, 2);
        wait_cmd(C_REF, 20, f);
        check(f && !sd_cke, "R7 self-refresh entry", int'({f, sd_cke}), 2);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (sd_cke || !sd_busy) viol++;
        end
        check(viol == 0, "R9 held in self-refresh", viol, 0);
        mode = 1'b0;
        n = 0; viol = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (sd_busy) begin
                n++;
                if (!sd_cke || cmd() != C_NOP) viol++;
            end else break;
        end
        check(n == T_XSR && viol == 0, "R10 self exit", n, T_XSR);
        check(!rf_req && sd_cke, "R10 released", int'(rf_req), 0);
        en = 1'b0;
    endtask

    task automatic t_deep();
        bit f;
        int n = 0;
        int viol = 0;
        do_reset();
        ivl = 16'hFFFF; grant = 1'b1; deep = 1'b1; en = 1'b1; mode = 1'b1;
        wait_cmd(C_DPD, 20, f);
        check(f && !sd_cke, "R8 deep entry", int'({f, sd_cke}), 2);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (sd_cke || !sd_busy) viol++;
        end
        check(viol == 0, "R9 held in deep", viol, 0);
        deep = 1'b0;
        viol = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (sd_busy) begin
                n++;
                if (!sd_cke || cmd() != C_NOP) viol++;
            end else break;
        end
        check(n == T_XSR && viol == 0, "R10 deep exit", n, T_XSR);
        en = 1'b0; mode = 1'b0;
    endtask

    task automatic t_edge();
        do_reset();
        lowf = 1'b1;
        @(negedge clk);
        check(edge_sel == 1'b1, "R11 falling", int'(edge_sel), 1);
        lowf = 1'b0;
        @(negedge clk);
        check(edge_sel == 1'b0, "R11 rising", int'(edge_sel), 0);
    endtask

    initial begin
        t_reset();
        t_off();
        t_period();
        t_grant();
        t_self();
        t_deep();
        t_edge();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule